// File: doc/BRIEF.md
# CCD Pixel Region Tagger with Per-Line Dark Averaging

This block sits behind the A/D converter of a full-frame CCD camera and labels every digitized sample with the part of the sensor it came from. A sample arrives with a valid qualifier. Two strobes can travel with it: one marks the first sample of a line and the other, given together with the first, marks the first line of a frame. The block counts the sample's column and row from these strobes. From the fixed layout of the sensor it derives a region code for each sample, and it gives the zero-based coordinates of every sample in the active picture.

Each line opens with a window of 20 light-shielded columns. The block sums those samples and, once the last one of the window is consumed, outputs their integer average as the black level for that line. The samples before the window (dummy and test positions) are never summed. The buffer, active, trailing shielded and tail test positions after the window are never summed either. A line strobe that arrives before the line has reached its last column aborts the line. It raises a one-cycle error flag, and the sample carrying the strobe becomes column 1 of the new line.

All outputs are registered and appear one clock after the sample that caused them. The geometry is set by parameters. The defaults describe a 4145-column, 4128-row sensor with 4096 by 4096 active pixels.

Top module: `ccd_region_tagger`

## Requirements
- R1: While reset is asserted, out_valid, act_valid, dark_valid and line_err are 0, and dark_avg, out_data and out_region are 0.
- R2: Each accepted sample appears one clock later with out_valid=1 and its data unchanged. out_region encodes the column class on every row: 1 for columns 1-11 (dummy), 2 for columns 12-15 and 4143-4145 (test), 3 for columns 16-35 (shielded window), 6 for columns 4134-4142 (trailing shielded). When out_valid=0, out_region and out_data are 0.
- R3: Columns 36-4133 take the class of their row. Rows 1-20 and 4120-4128 give 3 (dark). Rows 21 and 4118 give 4 (buffer). Row 4119 gives 2 (test). On rows 22-4117, columns 36 and 4133 give 4 (buffer) and columns 37-4132 give 5 (active).
- R4: act_valid is 1 exactly when the output sample has region 5. act_x is the column minus 37 and act_y is the row minus 22. Both are 0 whenever act_valid is 0.
- R5: dark_valid pulses for one cycle together with the output of column 35. dark_avg then equals the floor of the sum of that line's column 16-35 samples divided by 20, and holds its value between pulses.
- R6: Samples outside columns 16-35 have no effect on dark_avg, whatever their data.
- R7: A line strobe together with the frame strobe sets the row to 1. A line strobe alone advances the row by one, and the row saturates at 4128.
- R8: A line strobe with pix_valid=1, while a line is open below column 4145, gives line_err=1 on that sample's output. That sample is column 1 of a new line, and the average restarts. A line strobe after a complete line gives line_err=0.
- R9: Strobes and data are ignored while pix_valid=0. A valid sample without a line strobe, before any line or after column 4145, is dropped (out_valid=0). A frame strobe without a line strobe leaves the row unchanged.
- R10: The window sum cannot overflow: 20 samples at full scale give dark_avg at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Sample qualifier |
| line_start | input | 1 | First sample of a line |
| frame_start | input | 1 | First line of a frame (with line_start) |
| pix_data | input | 12 | Digitized sample |
| out_valid | output | 1 | Tagged sample present |
| out_region | output | 3 | Region code |
| out_data | output | 12 | Sample data |
| act_valid | output | 1 | Active pixel present |
| act_x | output | 12 | Active column, zero-based |
| act_y | output | 12 | Active row, zero-based |
| dark_valid | output | 1 | Per-line black level strobe |
| dark_avg | output | 12 | Per-line black level |
| line_err | output | 1 | Short line detected |

## Verification
The collision that matters is between a line abort and the start of the next line. Both happen on the same output cycle: the error flag, the dummy tag for column 1, the row advance and the restart of the shielded-window sum. The bench provokes this with directed aborts inside the shielded window and one column before the last. It adds random aborts at random columns, so a partial sum is always pending when the abort arrives. A reference model judges each case. The average reported for the following line must contain none of the partial sum, and the flag must appear on exactly the sample that carried the early strobe.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

    typedef enum logic [2:0] {
        RGN_NONE  = 3'd0,
        RGN_DUMMY = 3'd1,
        RGN_TEST  = 3'd2,
        RGN_DARK  = 3'd3,
        RGN_BUF   = 3'd4,
        RGN_ACT   = 3'd5,
        RGN_SHLD  = 3'd6
    } region_e;

    typedef enum logic [1:0] {
        ROW_DARK,
        ROW_BUF,
        ROW_ACT,
        ROW_TEST
    } rowkind_e;

endpackage

// File: rtl/ccd_pos_counter.sv
module ccd_pos_counter #(
    parameter int LINE_LEN    = 4145,
    parameter int FRAME_LINES = 4128,
    parameter int HW          = 13,
    parameter int VW          = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          line_start,
    input  logic          frame_start,
    output logic          take,
    output logic          restart,
    output logic          abort,
    output logic [HW-1:0] hcur,
    output logic [VW-1:0] vcur
);
    localparam logic [HW-1:0] C_LAST = HW'(LINE_LEN);
    localparam logic [VW-1:0] C_ROWS = VW'(FRAME_LINES);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t pos_q, pos_d;
    logic open_line;

    always_comb begin
        open_line = (pos_q.h != '0) && (pos_q.h != C_LAST);
        take      = pix_valid && (line_start || open_line);
        restart   = pix_valid && line_start;
        abort     = pix_valid && line_start && open_line;
        hcur      = line_start ? HW'(1) : pos_q.h + HW'(1);
        if (line_start) begin
            if (frame_start)          vcur = VW'(1);
            else if (pos_q.v == C_ROWS) vcur = pos_q.v;
            else                      vcur = pos_q.v + VW'(1);
        end else begin
            vcur = pos_q.v;
        end
        pos_d = pos_q;
        if (take) begin
            pos_d.h = hcur;
            pos_d.v = vcur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/ccd_region_decode.sv
module ccd_region_decode
    import ccd_tag_pkg::*;
#(
    parameter int DUMMY_N     = 11,
    parameter int TEST_N      = 4,
    parameter int DARK_N      = 20,
    parameter int ACT_N       = 4096,
    parameter int TRAIL_N     = 9,
    parameter int TOP_DARK    = 20,
    parameter int ACT_ROWS    = 4096,
    parameter int TEST_ROWS   = 1,
    parameter int HW          = 13,
    parameter int VW          = 13,
    parameter int AXW         = 12,
    parameter int AYW         = 12
) (
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] v,
    output region_e       region,
    output logic          in_win,
    output logic          win_last,
    output logic [AXW-1:0] ax,
    output logic [AYW-1:0] ay
);
    // column boundaries (last column of each span, 1-based)
    localparam logic [HW-1:0] C_DUM_END = HW'(DUMMY_N);
    localparam logic [HW-1:0] C_TST_END = HW'(DUMMY_N + TEST_N);
    localparam logic [HW-1:0] C_DRK_END = HW'(DUMMY_N + TEST_N + DARK_N);
    localparam logic [HW-1:0] C_BUF_L   = HW'(DUMMY_N + TEST_N + DARK_N + 1);
    localparam logic [HW-1:0] C_ACT0    = HW'(DUMMY_N + TEST_N + DARK_N + 2);
    localparam logic [HW-1:0] C_BUF_R   = HW'(DUMMY_N + TEST_N + DARK_N + ACT_N + 2);
    localparam logic [HW-1:0] C_SHD_END = HW'(DUMMY_N + TEST_N + DARK_N + ACT_N + 2 + TRAIL_N);
    // row boundaries
    localparam logic [VW-1:0] R_TD_END  = VW'(TOP_DARK);
    localparam logic [VW-1:0] R_BUF1    = VW'(TOP_DARK + 1);
    localparam logic [VW-1:0] R_ACT0    = VW'(TOP_DARK + 2);
    localparam logic [VW-1:0] R_ACT_END = VW'(TOP_DARK + 1 + ACT_ROWS);
    localparam logic [VW-1:0] R_BUF2    = VW'(TOP_DARK + 2 + ACT_ROWS);
    localparam logic [VW-1:0] R_TST_END = VW'(TOP_DARK + 2 + ACT_ROWS + TEST_ROWS);

    rowkind_e rk;

    always_comb begin
        if (v <= R_TD_END)       rk = ROW_DARK;
        else if (v == R_BUF1)    rk = ROW_BUF;
        else if (v <= R_ACT_END) rk = ROW_ACT;
        else if (v == R_BUF2)    rk = ROW_BUF;
        else if (v <= R_TST_END) rk = ROW_TEST;
        else                     rk = ROW_DARK;

        if (h <= C_DUM_END)      region = RGN_DUMMY;
        else if (h <= C_TST_END) region = RGN_TEST;
        else if (h <= C_DRK_END) region = RGN_DARK;
        else if (h <= C_BUF_R) begin
            unique case (rk)
                ROW_ACT:  region = (h == C_BUF_L || h == C_BUF_R) ? RGN_BUF : RGN_ACT;
                ROW_BUF:  region = RGN_BUF;
                ROW_TEST: region = RGN_TEST;
                default:  region = RGN_DARK;
            endcase
        end
        else if (h <= C_SHD_END) region = RGN_SHLD;
        else                     region = RGN_TEST;

        in_win   = (h > C_TST_END) && (h <= C_DRK_END);
        win_last = (h == C_DRK_END);
        ax = (region == RGN_ACT) ? AXW'(h - C_ACT0) : '0;
        ay = (region == RGN_ACT) ? AYW'(v - R_ACT0) : '0;
    end
endmodule

// File: rtl/ccd_dark_avg.sv
module ccd_dark_avg #(
    parameter int DW     = 12,
    parameter int DARK_N = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          restart,
    input  logic          in_win,
    input  logic          win_last,
    input  logic [DW-1:0] sample,
    output logic          fire,
    output logic [DW-1:0] avg
);
    localparam int SW = DW + $clog2(DARK_N + 1);

    typedef struct packed {
        logic [SW-1:0] sum;
    } acc_t;

    acc_t acc_q, acc_d;
    logic [SW-1:0] base, sum_new;

    always_comb begin
        base    = restart ? '0 : acc_q.sum;
        sum_new = base + (in_win ? SW'(sample) : '0);
        acc_d   = acc_q;
        if (take) acc_d.sum = sum_new;
        fire = take && win_last;
        avg  = DW'(sum_new / SW'(DARK_N));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
    import ccd_tag_pkg::*;
#(
    parameter int DW          = 12,
    parameter int DUMMY_N     = 11,
    parameter int TEST_N      = 4,
    parameter int DARK_N      = 20,
    parameter int ACT_N       = 4096,
    parameter int TRAIL_N     = 9,
    parameter int TAIL_TEST_N = 3,
    parameter int TOP_DARK    = 20,
    parameter int ACT_ROWS    = 4096,
    parameter int TEST_ROWS   = 1,
    parameter int BOT_DARK    = 9,
    localparam int AXW = (ACT_N > 1) ? $clog2(ACT_N) : 1,
    localparam int AYW = (ACT_ROWS > 1) ? $clog2(ACT_ROWS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pix_valid,
    input  logic           line_start,
    input  logic           frame_start,
    input  logic [DW-1:0]  pix_data,
    output logic           out_valid,
    output logic [2:0]     out_region,
    output logic [DW-1:0]  out_data,
    output logic           act_valid,
    output logic [AXW-1:0] act_x,
    output logic [AYW-1:0] act_y,
    output logic           dark_valid,
    output logic [DW-1:0]  dark_avg,
    output logic           line_err
);
    localparam int LINE_LEN    = DUMMY_N + TEST_N + DARK_N + ACT_N + 2 + TRAIL_N + TAIL_TEST_N;
    localparam int FRAME_LINES = TOP_DARK + ACT_ROWS + 2 + TEST_ROWS + BOT_DARK;
    localparam int HW          = $clog2(LINE_LEN + 1);
    localparam int VW          = $clog2(FRAME_LINES + 1);

    typedef struct packed {
        logic           valid;
        region_e        region;
        logic [DW-1:0]  data;
        logic           act;
        logic [AXW-1:0] ax;
        logic [AYW-1:0] ay;
        logic           dvalid;
        logic [DW-1:0]  davg;
        logic           err;
    } out_t;

    logic           take, restart, abort, in_win, win_last, fire;
    logic [HW-1:0]  hcur;
    logic [VW-1:0]  vcur;
    region_e        rgn;
    logic [AXW-1:0] ax;
    logic [AYW-1:0] ay;
    logic [DW-1:0]  avg;
    out_t           o_q, o_d;

    ccd_pos_counter #(
        .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HW(HW), .VW(VW)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
        .frame_start(frame_start), .take(take), .restart(restart), .abort(abort),
        .hcur(hcur), .vcur(vcur)
    );

    ccd_region_decode #(
        .DUMMY_N(DUMMY_N), .TEST_N(TEST_N), .DARK_N(DARK_N), .ACT_N(ACT_N),
        .TRAIL_N(TRAIL_N), .TOP_DARK(TOP_DARK), .ACT_ROWS(ACT_ROWS),
        .TEST_ROWS(TEST_ROWS), .HW(HW), .VW(VW), .AXW(AXW), .AYW(AYW)
    ) u_dec (
        .h(hcur), .v(vcur), .region(rgn), .in_win(in_win), .win_last(win_last),
        .ax(ax), .ay(ay)
    );

    ccd_dark_avg #(.DW(DW), .DARK_N(DARK_N)) u_dark (
        .clk(clk), .rst_n(rst_n), .take(take), .restart(restart), .in_win(in_win),
        .win_last(win_last), .sample(pix_data), .fire(fire), .avg(avg)
    );

    always_comb begin
        o_d        = o_q;
        o_d.valid  = take;
        o_d.region = take ? rgn : RGN_NONE;
        o_d.data   = take ? pix_data : '0;
        o_d.act    = take && (rgn == RGN_ACT);
        o_d.ax     = o_d.act ? ax : '0;
        o_d.ay     = o_d.act ? ay : '0;
        o_d.dvalid = fire;
        if (fire) o_d.davg = avg;
        o_d.err    = abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid  = o_q.valid;
    assign out_region = o_q.region;
    assign out_data   = o_q.data;
    assign act_valid  = o_q.act;
    assign act_x      = o_q.ax;
    assign act_y      = o_q.ay;
    assign dark_valid = o_q.dvalid;
    assign dark_avg   = o_q.davg;
    assign line_err   = o_q.err;
endmodule

// File: rtl/ccd_tag_chk.sv
module ccd_tag_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid,
    input logic          out_valid,
    input logic [2:0]    out_region,
    input logic          act_valid,
    input logic          dark_valid,
    input logic [DW-1:0] dark_avg,
    input logic          line_err
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !line_err && !dark_valid && !act_valid));

    // R4
    act_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (out_valid && out_region == 3'd5));

    // R5
    dark_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dark_valid |-> (out_valid && out_region == 3'd3));

    // R5
    dark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dark_valid |-> $stable(dark_avg));

    // R8
    abort_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> (out_valid && out_region == 3'd1));

    // R9
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R2
    none_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_region == 3'd0 && !act_valid));
endmodule

bind ccd_region_tagger ccd_tag_chk #(.DW(DW)) u_tag_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .out_valid(out_valid),
    .out_region(out_region), .act_valid(act_valid), .dark_valid(dark_valid),
    .dark_avg(dark_avg), .line_err(line_err)
);

// File: tb/tb_ccd_region_tagger.sv
`timescale 1ns/1ps
module tb_ccd_region_tagger;
    localparam int DW   = 12;
    localparam int LINE = 57;   // 11+4+20+1+8+1+9+3
    localparam int ROWS = 10;   // 2+1+3+1+1+2
    localparam int MAXV = 4095;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic out_valid, act_valid, dark_valid, line_err;
    logic [2:0] out_region;
    logic [DW-1:0] out_data, dark_avg;
    logic [2:0] act_x;
    logic [1:0] act_y;

    always #2 clk = ~clk;

    ccd_region_tagger #(
        .DW(DW), .ACT_N(8), .TOP_DARK(2), .ACT_ROWS(3), .BOT_DARK(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
        .frame_start(frame_start), .pix_data(pix_data), .out_valid(out_valid),
        .out_region(out_region), .out_data(out_data), .act_valid(act_valid),
        .act_x(act_x), .act_y(act_y), .dark_valid(dark_valid), .dark_avg(dark_avg),
        .line_err(line_err)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // expectation for the sample driven last
    bit e_valid = 0, e_act = 0, e_dv = 0, e_err = 0;
    int e_rgn = 0, e_data = 0, e_ax = 0, e_ay = 0, e_davg = 0;
    int mh = 0, mv = 0, msum = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // region code expected from R2/R3 for the bench geometry
    function automatic int exp_rgn(int h, int v);
        int rk; // 0 dark, 1 buffer, 2 active, 3 test
        if (v <= 2)       rk = 0;
        else if (v == 3)  rk = 1;
        else if (v <= 6)  rk = 2;
        else if (v == 7)  rk = 1;
        else if (v == 8)  rk = 3;
        else              rk = 0;
        if (h <= 11) return 1;
        if (h <= 15) return 2;
        if (h <= 35) return 3;
        if (h <= 45) begin
            if (rk == 2) return (h == 36 || h == 45) ? 4 : 5;
            if (rk == 0) return 3;
            if (rk == 1) return 4;
            return 2;
        end
        if (h <= 54) return 6;
        return 2;
    endfunction

    task automatic compare();
        chk(e_valid ? "R2 valid" : "R9 dropped", int'(out_valid), int'(e_valid));
        chk("R2 data", int'(out_data), e_data);
        chk("R2 R3 R7 region", int'(out_region), e_rgn);
        chk("R4 act_valid", int'(act_valid), int'(e_act));
        chk("R4 act_x", int'(act_x), e_ax);
        chk("R4 act_y", int'(act_y), e_ay);
        chk("R5 dark_valid", int'(dark_valid), int'(e_dv));
        chk("R5 R6 R10 dark_avg", int'(dark_avg), e_davg);
        chk("R8 line_err", int'(line_err), int'(e_err));
    endtask

    task automatic drive(input bit v, input bit ls, input bit fs, input int d);
        bit open, take;
        int h, vv;
        @(negedge clk);
        compare();
        pix_valid   = v;
        line_start  = ls;
        frame_start = fs;
        pix_data    = DW'(d);
        open  = (mh != 0) && (mh != LINE);
        take  = v && (ls || open);
        e_err = v && ls && open;
        e_dv  = 0;
        if (take) begin
            h  = ls ? 1 : mh + 1;
            vv = !ls ? mv : (fs ? 1 : (mv == ROWS ? mv : mv + 1));
            if (ls) msum = 0;
            if (h >= 16 && h <= 35) msum += (d & MAXV);
            if (h == 35) begin
                e_dv = 1;
                e_davg = msum / 20;
            end
            e_valid = 1;
            e_data  = d & MAXV;
            e_rgn   = exp_rgn(h, vv);
            e_act   = (e_rgn == 5);
            e_ax    = e_act ? h - 37 : 0;
            e_ay    = e_act ? vv - 4 : 0;
            mh = h;
            mv = vv;
        end else begin
            e_valid = 0; e_data = 0; e_rgn = 0; e_act = 0; e_ax = 0; e_ay = 0;
        end
    endtask

    // mode 1: full-scale data (R10); stray: index carrying a lone frame strobe (R9)
    task automatic send_line(input bit fs, input int n, input int mode, input int stray);
        for (int i = 1; i <= n; i++) begin
            if ($urandom % 8 == 0)
                drive(0, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 4096));
            drive(1, i == 1, (fs && i == 1) || (i == stray),
                  mode == 1 ? MAXV : int'($urandom % 4096));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0D));
        repeat (5) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 act_valid", int'(act_valid), 0);
        chk("R1 dark_valid", int'(dark_valid), 0);
        chk("R1 line_err", int'(line_err), 0);
        chk("R1 dark_avg", int'(dark_avg), 0);
        chk("R1 out_region", int'(out_region), 0);
        rst_n = 1'b1;

        // R9: samples before any line, frame strobe alone
        drive(1, 0, 0, 77);
        drive(1, 0, 1, 5);
        // R3 R7: full frame plus two extra lines (row saturation)
        for (int ln = 0; ln < ROWS + 2; ln++) send_line(ln == 0, LINE, 0, 0);
        // R9: samples after the last column
        repeat (3) drive(1, 0, 0, 99);
        // R9: lone frame strobe inside a line leaves the row
        send_line(1, LINE, 0, 0);
        send_line(0, LINE, 0, 5);
        // R10: full-scale lines
        send_line(0, LINE, 1, 0);
        send_line(0, LINE, 1, 0);
        // R8: aborts inside the window, one short of the end, right after start
        send_line(0, 25, 0, 0);
        send_line(0, LINE, 0, 0);
        send_line(0, LINE - 1, 0, 0);
        send_line(0, LINE, 0, 0);
        send_line(0, 1, 0, 0);
        send_line(0, LINE, 0, 0);
        // random frames with random aborts
        for (int f = 0; f < 4; f++) begin
            for (int ln = 0; ln < ROWS + 1; ln++) begin
                int n;
                n = ($urandom % 6 == 0) ? 1 + int'($urandom % LINE) : LINE;
                send_line(ln == 0, n, 0, 0);
            end
        end
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule